// File: doc/BRIEF.md
# Multiply Pipeline Issue Interlock

The block sits between the instruction decoder and a SIMD multiply/accumulate pipeline. Each cycle the decoder presents one operation code with a valid flag. The block decodes the code into a multiply-pipe class from 1 to 4, or 0 for operations that do not use that pipe. It then decides whether the operation may issue in this cycle or must stall.

The wait before the next multiply-pipe operation depends on two things: the group of the operation that last issued into the pipe and the class of the operation now waiting. When an operation issues, two small countdown registers are loaded, one for a following class 1/2 operation and one for a following class 3/4 operation. Both count down by one every cycle until they reach zero. A waiting operation issues once the countdown for its class has reached zero. Operations outside the multiply pipe always issue at once. They never reload the countdowns, and the countdowns keep running while they pass.

Top module: `mpipe_issue_lock`

## Requirements
- R1: `op_class` decodes `op_code` as follows. 1 (accumulate-only) gives class 1. 2 (multiply), 3 (multiply-accumulate) and 4 (multiply-add) give class 2. 5 (sum of absolute differences), 6 (halfword MIA) and 7 (selected-half MIA) give class 3. 8 (full MIA) gives class 4. Every other code gives class 0 (not a multiply-pipe operation).
- R2: `main_pipe` is 1 exactly for codes 5, 6, 7 and 8, which also occupy the main execution pipe.
- R3: After an accumulate-only operation issues, a multiply-pipe operation of any class can issue in the very next cycle.
- R4: After any class 2 or class 3 operation issues, a class 1 or 2 operation presented in the next cycle stalls for one cycle. A class 3 or 4 operation presented in the next cycle issues at once.
- R5: After a full MIA issues, a class 1 or 2 operation presented in the next cycle stalls for two cycles. A class 3 or 4 operation presented in the next cycle stalls for one cycle.
- R6: The countdown advances every cycle, including idle cycles and cycles carrying other operations. With g cycles between the two multiply-pipe operations, the stall lasts max(0, D-1-g) cycles, where D is the wait given in R3 to R5.
- R7: A valid operation of class 0 gets `issue`=1 and `stall`=0 in the same cycle. It does not change the stall that a later multiply-pipe operation sees.
- R8: A multiply-pipe operation held valid keeps `stall`=1 on consecutive cycles. `issue` rises in the first cycle in which the wait has elapsed.
- R9: After reset, the first multiply-pipe operation issues in the cycle it is presented.
- R10: `issue` and `stall` are never both 1, and both are 0 while `op_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | OPW | Operation code |
| issue | output | 1 | Presented operation issues this cycle |
| stall | output | 1 | Presented operation must be held |
| op_class | output | 3 | Decoded multiply-pipe class, 0 = none |
| main_pipe | output | 1 | Operation also uses the main execution pipe |

## Verification
The assertions assume that the decoder keeps a stalled operation on `op_valid`/`op_code` until it issues. They also assume that a cycle in which `issue` is high is the moment that operation enters the pipe. The stimulus follows both rules: it holds each waiting operation unchanged until `issue` is seen, and only then moves on. It sweeps every pair of multiply-pipe operations with gaps of 0 to 3 cycles, filling the gaps with idle cycles and other operations in turn.

// File: rtl/mpipe_issue_lock.sv
module mpipe_issue_lock #(
  parameter int OPW = 4,
  parameter int CW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  output logic           issue,
  output logic           stall,
  output logic [2:0]     op_class,
  output logic           main_pipe
);

  localparam logic [OPW-1:0] C_ACC    = OPW'(1);
  localparam logic [OPW-1:0] C_MUL    = OPW'(2);
  localparam logic [OPW-1:0] C_MAC    = OPW'(3);
  localparam logic [OPW-1:0] C_MADD   = OPW'(4);
  localparam logic [OPW-1:0] C_SAD    = OPW'(5);
  localparam logic [OPW-1:0] C_MIAH   = OPW'(6);
  localparam logic [OPW-1:0] C_MIAS   = OPW'(7);
  localparam logic [OPW-1:0] C_MIAF   = OPW'(8);

  localparam logic [CW-1:0] ZERO      = '0;
  localparam logic [CW-1:0] ONE       = CW'(1);
  localparam logic [CW-1:0] HVY_LO    = CW'(2);
  localparam logic [CW-1:0] HVY_HI    = CW'(1);
  localparam logic [CW-1:0] NRM_LO    = CW'(1);
  localparam logic [CW-1:0] NRM_HI    = CW'(0);

  logic [CW-1:0] wait_lo, wait_hi;
  logic          is_mp, lo_cls, ready, fire;

  always_comb begin
    case (op_code)
      C_ACC:                  op_class = 3'd1;
      C_MUL, C_MAC, C_MADD:   op_class = 3'd2;
      C_SAD, C_MIAH, C_MIAS:  op_class = 3'd3;
      C_MIAF:                 op_class = 3'd4;
      default:                op_class = 3'd0;
    endcase
  end

  assign is_mp     = op_class != 3'd0;
  assign main_pipe = op_class >= 3'd3;
  assign lo_cls    = op_class == 3'd1 || op_class == 3'd2;
  assign ready     = lo_cls ? (wait_lo == ZERO) : (wait_hi == ZERO);
  assign stall     = op_valid & is_mp & ~ready;
  assign issue     = op_valid & (~is_mp | ready);
  assign fire      = issue & is_mp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_lo <= ZERO;
      wait_hi <= ZERO;
    end else if (fire) begin
      case (op_class)
        3'd1:    begin wait_lo <= ZERO;   wait_hi <= ZERO;   end
        3'd4:    begin wait_lo <= HVY_LO; wait_hi <= HVY_HI; end
        default: begin wait_lo <= NRM_LO; wait_hi <= NRM_HI; end
      endcase
    end else begin
      if (wait_lo != ZERO) wait_lo <= wait_lo - ONE;
      if (wait_hi != ZERO) wait_hi <= wait_hi - ONE;
    end
  end

endmodule

// File: rtl/mpipe_issue_lock_chk.sv
module mpipe_issue_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       issue,
  input logic       stall,
  input logic [2:0] op_class
);

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && stall));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!issue && !stall));

  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 3'd0) |-> (issue && !stall));

  assert_acc_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_class == 3'd1) |=> !stall);

  assert_heavy_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_class == 3'd4) |=> !(issue && (op_class == 3'd1 || op_class == 3'd2)));

  assert_normal_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (op_class == 3'd2 || op_class == 3'd3)) |=>
      ((op_valid && op_class >= 3'd3) -> issue));

endmodule

bind mpipe_issue_lock mpipe_issue_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
  .issue(issue), .stall(stall), .op_class(op_class)
);

// File: tb/tb_mpipe_issue_lock.sv
module tb_mpipe_issue_lock;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       op_valid = 0;
  logic [3:0] op_code = 0;
  logic       issue, stall, main_pipe;
  logic [2:0] op_class;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mpipe_issue_lock dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .issue(issue), .stall(stall), .op_class(op_class), .main_pipe(main_pipe)
  );

  function automatic int exp_class(input int c);
    if (c == 1) return 1;
    if (c >= 2 && c <= 4) return 2;
    if (c >= 5 && c <= 7) return 3;
    if (c == 8) return 4;
    return 0;
  endfunction

  function automatic int exp_delay(input int p, input int n);
    int pc = exp_class(p), nc = exp_class(n);
    if (pc == 1) return 1;
    if (pc == 4) return (nc <= 2) ? 3 : 2;
    return (nc <= 2) ? 2 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; op_valid = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    #1;
    chk(!issue && !stall, "R10 reset idle", {issue, stall}, 0);

    for (int c = 0; c < 16; c++) begin
      op_code = 4'(c); op_valid = 0; #1;
      chk(op_class == 3'(exp_class(c)), "R1 decode", op_class, exp_class(c));
      chk(main_pipe == (c >= 5 && c <= 8), "R2 main pipe", main_pipe, (c >= 5 && c <= 8));
      chk(!issue && !stall, "R10 invalid", {issue, stall}, 0);
    end

    for (int p = 1; p <= 8; p++)
      for (int n = 1; n <= 8; n++)
        for (int g = 0; g < 4; g++) begin
          int d, expst, cnt;
          string rq;
          do_reset();
          op_valid = 1; op_code = 4'(p); #1;
          chk(issue && !stall, "R9 first issue", issue, 1);
          for (int i = 0; i < g; i++) begin
            @(negedge clk);
            if (i % 2 == 0) begin
              op_valid = 1; op_code = 4'd9; #1;
              chk(issue && !stall, "R7 pass-through", issue, 1);
            end else begin
              op_valid = 0; #1;
              chk(!issue && !stall, "R10 idle", {issue, stall}, 0);
            end
          end
          @(negedge clk);
          op_valid = 1; op_code = 4'(n); #1;
          d = exp_delay(p, n);
          expst = d - 1 - g; if (expst < 0) expst = 0;
          cnt = 0;
          while (stall && cnt < 8) begin
            chk(!issue, "R8 held", issue, 0);
            cnt++;
            @(negedge clk); #1;
          end
          chk(issue, "R8 grant after stall", issue, 1);
          if (exp_class(p) == 1) rq = "R3";
          else if (exp_class(p) == 4) rq = "R5";
          else rq = "R4";
          if (g > 0) rq = {rq, "/R6/R7"};
          chk(cnt == expst, rq, cnt, expst);
          @(negedge clk);
          op_valid = 0;
        end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule